// File: doc/BRIEF.md
# Lock and Fuse Bit Register

This block keeps the device's protection state: six lock bits, plus a low and a high fuse byte. Every bit follows the rule that a programmed bit is a zero and an unprogrammed bit is a one. The self-programming path sends lock-write requests to it. Software can change only the four boot lock bits, and only from one to zero. A chip-erase input is the only way to set them back to one. The fuse bytes are fixed by parameters.

A small controller state machine accepts each request and applies it in the following cycle. It has three states:

- `ST_IDLE`: nothing to do.
- `ST_WRITE`: apply the captured program mask.
- `ST_ERASE`: restore all lock bits.

Transitions are evaluated the same way from every state:

- `chip_erase_i` goes to `ST_ERASE`. This takes priority over a write.
- Otherwise `lock_wr_i` goes to `ST_WRITE`.
- Otherwise the next state is `ST_IDLE`.

A read pointer selects what appears on the readback byte. The block also decodes the two application-section boot lock bits into a write-allow flag and a read-allow flag.

Top module: `lockfuse_reg`

## Requirements
- R1: After reset the lock byte reads 0xFF, and both allow outputs are 1.
- R2: When `lock_wr_i` is high, each zero in `lock_wr_data_i[5:2]` clears the matching lock byte bit (bit 5, 4, 3 or 2). The change is visible after the second rising edge that follows the request. After the first edge the old value is still shown.
- R3: A lock write never sets a bit from 0 back to 1. A one in the write data leaves the bit as it is.
- R4: Lock byte bits 7, 6, 1 and 0 always read as 1. The write data has no effect on them.
- R5: A chip erase restores every lock bit to 1, with the same two-edge latency as a write. If a write and an erase arrive in the same cycle, the erase wins.
- R6: Readback returns the fuse low byte for pointer 0x0000, the lock byte for pointer 0x0001, and the fuse high byte for pointer 0x0003.
- R7: Readback returns 0xFF for any other pointer value.
- R8: The outputs are decoded from lock bits {bit3, bit2}:

  | {bit3, bit2} | `app_wr_ok_o` | `app_rd_ok_o` |
  |---|---|---|
  | 11 | 1 | 1 |
  | 10 | 0 | 1 |
  | 00 | 0 | 0 |
  | 01 | 1 | 0 |

  So `app_wr_ok_o` follows bit 2 and `app_rd_ok_o` follows bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_erase_i | input | 1 | Restore all lock bits to one |
| lock_wr_i | input | 1 | Lock write request from the self-programming path |
| lock_wr_data_i | input | 6 | Lock write data, bit positions match lock byte bits 5..0 |
| rd_ptr_i | input | 16 | Readback selection pointer |
| rd_data_o | output | 8 | Readback byte |
| app_wr_ok_o | output | 1 | Stores to the application section allowed |
| app_rd_ok_o | output | 1 | Boot-section reads of the application section allowed |

## Verification
The assertions check every cycle for the following:

- No lock bit rises outside an erase.
- Bits 7, 6, 1 and 0 stay at one on readback.
- Unknown pointers return all ones.
- An erase state always leaves every bit at one.
- The allow flags agree with bits 2 and 3 of the readback byte.

Only the bench scenarios can show three things:

- The exact two-edge latency of a write.
- That erase wins over a simultaneous write.
- That a chain of masked writes accumulates to the expected byte, ending in each of the four protection modes.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
    localparam int LOCK_W = 6;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_ERASE = 2'd2
    } lfr_state_e;
endpackage

// File: rtl/lfr_ctrl.sv
module lfr_ctrl
    import lfr_pkg::*;
#(
    parameter logic [LOCK_W-1:0] WR_MASK = 6'b111100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chip_erase_i,
    input  logic                  lock_wr_i,
    input  logic [LOCK_W-1:0]     wr_data_i,
    output lfr_state_e            state_o,
    output logic                  prog_en_o,
    output logic                  erase_o,
    output logic [LOCK_W-1:0]     prog_mask_o
);
    lfr_state_e        state_q, state_d;
    logic [LOCK_W-1:0] mask_q;

    // next-state decision, identical entry rules from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_ERASE: begin
                if (chip_erase_i)   state_d = ST_ERASE;
                else if (lock_wr_i) state_d = ST_WRITE;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WRITE)
                mask_q <= ~wr_data_i & WR_MASK;
        end
    end

    // outputs from state
    always_comb begin
        prog_en_o = 1'b0;
        erase_o   = 1'b0;
        unique case (state_q)
            ST_WRITE: prog_en_o = 1'b1;
            ST_ERASE: erase_o   = 1'b1;
            default:  ;
        endcase
    end

    assign state_o     = state_q;
    assign prog_mask_o = mask_q;
endmodule

// File: rtl/lfr_lockbits.sv
module lfr_lockbits
    import lfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en_i,
    input  logic              erase_i,
    input  logic [LOCK_W-1:0] prog_mask_i,
    output logic [LOCK_W-1:0] lock_o
);
    logic [LOCK_W-1:0] lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_q <= '1;
        else if (erase_i)
            lock_q <= '1;
        else if (prog_en_i)
            lock_q <= lock_q & ~prog_mask_i;
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/lfr_readmux.sv
module lfr_readmux
    import lfr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FUSE_LO_VAL = 8'hE1,
    parameter logic [BYTE_W-1:0] FUSE_HI_VAL = 8'h99,
    parameter logic [PTR_W-1:0]  PTR_FUSE_LO = 16'h0000,
    parameter logic [PTR_W-1:0]  PTR_LOCK    = 16'h0001,
    parameter logic [PTR_W-1:0]  PTR_FUSE_HI = 16'h0003
) (
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [LOCK_W-1:0] lock_i,
    output logic [BYTE_W-1:0] data_o
);
    localparam int PAD_W = BYTE_W - LOCK_W;

    logic [BYTE_W-1:0] lock_byte;
    assign lock_byte = {{PAD_W{1'b1}}, lock_i};

    always_comb begin
        if (ptr_i == PTR_LOCK)         data_o = lock_byte;
        else if (ptr_i == PTR_FUSE_LO) data_o = FUSE_LO_VAL;
        else if (ptr_i == PTR_FUSE_HI) data_o = FUSE_HI_VAL;
        else                           data_o = '1;
    end
endmodule

// File: rtl/lockfuse_reg.sv
module lockfuse_reg
    import lfr_pkg::*;
#(
    parameter logic [7:0] FUSE_LO_VAL = 8'hE1,
    parameter logic [7:0] FUSE_HI_VAL = 8'h99
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chip_erase_i,
    input  logic        lock_wr_i,
    input  logic [5:0]  lock_wr_data_i,
    input  logic [15:0] rd_ptr_i,
    output logic [7:0]  rd_data_o,
    output logic        app_wr_ok_o,
    output logic        app_rd_ok_o
);
    localparam int APP_WR_BIT = 2;
    localparam int APP_RD_BIT = 3;

    lfr_state_e        state_q;
    logic              prog_en, erase_en;
    logic [LOCK_W-1:0] prog_mask;
    logic [LOCK_W-1:0] lock_q;

    lfr_ctrl #(.WR_MASK(6'b111100)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_erase_i (chip_erase_i),
        .lock_wr_i    (lock_wr_i),
        .wr_data_i    (lock_wr_data_i),
        .state_o      (state_q),
        .prog_en_o    (prog_en),
        .erase_o      (erase_en),
        .prog_mask_o  (prog_mask)
    );

    lfr_lockbits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_en_i   (prog_en),
        .erase_i     (erase_en),
        .prog_mask_i (prog_mask),
        .lock_o      (lock_q)
    );

    lfr_readmux #(
        .FUSE_LO_VAL (FUSE_LO_VAL),
        .FUSE_HI_VAL (FUSE_HI_VAL)
    ) u_rd (
        .ptr_i  (rd_ptr_i),
        .lock_i (lock_q),
        .data_o (rd_data_o)
    );

    // application-section protection decode (R8)
    assign app_wr_ok_o = lock_q[APP_WR_BIT];
    assign app_rd_ok_o = lock_q[APP_RD_BIT];
endmodule

// File: rtl/lfr_chk.sv
module lfr_chk
    import lfr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input lfr_state_e        state,
    input logic [LOCK_W-1:0] lock_q,
    input logic [15:0]       rd_ptr,
    input logic [7:0]        rd_data,
    input logic              app_wr_ok,
    input logic              app_rd_ok
);
    AST_NO_RISE_OUTSIDE_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ERASE) |=> ((lock_q & ~$past(lock_q)) == '0)); // R3

    AST_FIXED_BITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == 16'h0001) |-> (rd_data[7:6] == 2'b11 && rd_data[1:0] == 2'b11)); // R4

    AST_ERASE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |=> (lock_q == '1)); // R5

    AST_UNKNOWN_PTR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != 16'h0000 && rd_ptr != 16'h0001 && rd_ptr != 16'h0003) |-> (rd_data == 8'hFF)); // R7

    AST_DECODE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == 16'h0001) |-> (app_wr_ok == rd_data[2] && app_rd_ok == rd_data[3])); // R8
endmodule

bind lockfuse_reg lfr_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .lock_q    (lock_q),
    .rd_ptr    (rd_ptr_i),
    .rd_data   (rd_data_o),
    .app_wr_ok (app_wr_ok_o),
    .app_rd_ok (app_rd_ok_o)
);

// File: tb/test_lockfuse_reg.sv
module test_lockfuse_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_erase_i = 1'b0;
    logic        lock_wr_i = 1'b0;
    logic [5:0]  lock_wr_data_i = 6'h3F;
    logic [15:0] rd_ptr_i = 16'h0001;
    logic [7:0]  rd_data_o;
    logic        app_wr_ok_o, app_rd_ok_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lockfuse_reg i_lockfuse_reg (
        .clk(clk), .rst_n(rst_n), .chip_erase_i(chip_erase_i),
        .lock_wr_i(lock_wr_i), .lock_wr_data_i(lock_wr_data_i),
        .rd_ptr_i(rd_ptr_i), .rd_data_o(rd_data_o),
        .app_wr_ok_o(app_wr_ok_o), .app_rd_ok_o(app_rd_ok_o)
    );

    typedef struct packed {
        logic [5:0] wd;
        logic [7:0] exp_lock;
        logic       exp_wr;
        logic       exp_rd;
    } vec_t;

    // chained writes from the reset state (R2, R3, R4, R8)
    localparam vec_t VEC [6] = '{
        '{6'h3F, 8'hFF, 1'b1, 1'b1},
        '{6'h3B, 8'hFB, 1'b0, 1'b1},
        '{6'h3F, 8'hFB, 1'b0, 1'b1},
        '{6'h3C, 8'hFB, 1'b0, 1'b1},
        '{6'h37, 8'hF3, 1'b0, 1'b0},
        '{6'h1F, 8'hD3, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_ptr(input logic [15:0] p, output logic [7:0] d);
        @(negedge clk);
        rd_ptr_i = p;
        #1;
        d = rd_data_o;
    endtask

    task automatic do_write(input logic [5:0] d);
        @(negedge clk);
        lock_wr_i = 1'b1;
        lock_wr_data_i = d;
        @(negedge clk);
        lock_wr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_erase();
        @(negedge clk);
        chip_erase_i = 1'b1;
        @(negedge clk);
        chip_erase_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // r1_ reset state
        read_ptr(16'h0001, d); check("R1 lock byte after reset", d, 8'hFF);
        check("R1 allow flags after reset", {6'd0, app_wr_ok_o, app_rd_ok_o}, 8'h03);
        // R6 pointer selection
        read_ptr(16'h0000, d); check("R6 fuse low", d, 8'hE1);
        read_ptr(16'h0003, d); check("R6 fuse high", d, 8'h99);
        // R7 other pointers
        read_ptr(16'h0002, d); check("R7 ptr 0002", d, 8'hFF);
        read_ptr(16'hFFFF, d); check("R7 ptr FFFF", d, 8'hFF);
        read_ptr(16'h0101, d); check("R7 ptr 0101", d, 8'hFF);

        rd_ptr_i = 16'h0001;
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i].wd);
            #1;
            check("R2/R3/R4 lock byte after write", rd_data_o, VEC[i].exp_lock);
            check("R8 allow flags", {6'd0, app_wr_ok_o, app_rd_ok_o},
                  {6'd0, VEC[i].exp_wr, VEC[i].exp_rd});
        end

        // R5 erase restores
        do_erase();
        #1; check("R5 erase restores all", rd_data_o, 8'hFF);

        // R8 mode 01: bit3 programmed only
        do_write(6'h37);
        #1; check("R8 mode 01 flags", {6'd0, app_wr_ok_o, app_rd_ok_o}, 8'h02);

        // R2 latency: unchanged after first edge, changed after second
        @(negedge clk);
        lock_wr_i = 1'b1; lock_wr_data_i = 6'h2F;
        @(negedge clk);
        lock_wr_i = 1'b0;
        #1; check("R2 old value after first edge", rd_data_o, 8'hF7);
        @(negedge clk);
        #1; check("R2 new value after second edge", rd_data_o, 8'hE7);

        // R5 erase wins over a simultaneous write
        @(negedge clk);
        chip_erase_i = 1'b1; lock_wr_i = 1'b1; lock_wr_data_i = 6'h00;
        @(negedge clk);
        chip_erase_i = 1'b0; lock_wr_i = 1'b0;
        @(negedge clk);
        #1; check("R5 erase priority", rd_data_o, 8'hFF);

        // R4 zero data in fixed bits has no effect
        do_write(6'h3C);
        #1; check("R4 low bits unaffected", rd_data_o, 8'hFF);

        // R1 reset after programming
        do_write(6'h00);
        #1; check("R3 all boot bits programmed", rd_data_o, 8'hC3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1; check("R1 reset reloads ones", rd_data_o, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule